// File: doc/BRIEF.md
# Reset Cause and Memory Remap Controller

This block manages system reset for a small microcontroller. It accepts a power-on reset, a watchdog timeout, an external reset pin and a software request made through the register bus. Any of these produces a system reset pulse of fixed length. The block records in a status register which sources caused resets. Software reads that status, clears bits through a separate write-only clear register, and starts a software reset by writing the status register.

The block also holds a one-bit remap control that selects whether RAM or flash appears at address zero. Every reset forces the control back to flash. A second reset output, for the watchdog, is driven only during power-on reset, so the watchdog's settings survive the other reset kinds.

The register bus is a plain single-cycle strobe interface. A write takes effect on the clock edge where `wr_en` is high. Read data is combinational from `addr`. There is no back-pressure, and a strobe is never stalled.

Top module: `reset_cause_ctl`

## Requirements
- R1: While `por_n` is low and for 17 clock cycles after it is released (two release-synchronizer stages, then 16 counted cycles), `sys_rst` and `wdt_rst` are high. After a power-on reset the status register reads 0x01 and the remap control is 0, whatever their values were before.
- R2: After a watchdog or software trigger, `sys_rst` is high for exactly 16 cycles, starting at the edge that accepts the trigger. A new trigger during the pulse restarts the 16-cycle count.
- R3: A `wdog_evt` pulse sets status bit 1 and leaves the other status bits unchanged.
- R4: `ext_rst_n` passes through a two-flop synchronizer. Holding it low for H cycles keeps `sys_rst` high for H+15 cycles in total and sets status bit 3 without clearing other bits.
- R5: A write to offset 0x230 with data bit 2 at 1 sets status bit 2 and starts a software reset. All other data bits of that write are ignored.
- R6: A write to offset 0x234 clears every status bit whose data bit is 1. Reads of 0x234 return 0, and status bits 7:4 always read 0.
- R7: If status bit 2 is set, a write to 0x234 with data bit 2 at 0 starts another software reset, and bit 2 stays set.
- R8: Bit 0 of offset 0x220 drives `remap_ram` (1 maps RAM at address zero). Bits 7:1 read 0 and ignore writes, and every reset kind returns the bit to 0.
- R9: `wdt_rst` is asserted only by power-on reset. Watchdog, software and external resets leave it low.
- R10: Bus writes are ignored while `sys_rst` is high.
- R11: If a hardware event and a clear of the same status bit fall in one cycle, the bit ends up set. Other bits named in the clear are still cleared.
- R12: Reads of any offset other than 0x220, 0x230 or 0x234 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset from the analog detector, active low, asynchronous |
| wdog_evt | input | 1 | Watchdog timeout pulse, synchronous to `clk` |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte offset |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, combinational from `addr` |
| sys_rst | output | 1 | System reset pulse, active high |
| wdt_rst | output | 1 | Watchdog block reset, active high, power-on only |
| remap_ram | output | 1 | 1 maps RAM at address zero, 0 maps flash |

## Verification
The delicate overlap is a clear-register write landing in the same cycle as a watchdog event. Three things happen at once: bits are cleared, bit 1 is set, and the pulse and remap are restarted. The bench drives a clear of all four bits together with a `wdog_evt` pulse on one edge. It then expects the status to read exactly 0x02, with a 16-cycle pulse and the remap control back at 0. A second overlap is the retrigger by a clear write that spares bit 2, which must both start a pulse and keep the bit set.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 8;
  localparam int CAUSE_W  = 4;

  localparam logic [ADDR_W-1:0] OFS_REMAP  = 12'h220;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h230;
  localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h234;

  // status bit positions (software decodes these)
  localparam int BIT_POR  = 0;
  localparam int BIT_WDOG = 1;
  localparam int BIT_SOFT = 2;
  localparam int BIT_EXT  = 3;

  typedef struct packed {
    logic wr_status;
    logic wr_clear;
    logic wr_remap;
  } reg_wr_t;
endpackage

// File: rtl/rcc_sync.sv
module rcc_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain[0] <= RST_VAL;
          else         chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain[i] <= RST_VAL;
          else         chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rcc_cause.sv
module rcc_cause
  import rcc_pkg::*;
#(
  parameter int W = CAUSE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_ok,
  input  reg_wr_t      wr,
  input  logic [W-1:0] wdata,
  input  logic         wdog_hit,
  input  logic         ext_hit,
  output logic [W-1:0] status,
  output logic         soft_fire
);
  logic [W-1:0] st_q, st_d;
  logic         soft_req, soft_retrig;

  assign soft_req    = bus_ok && wr.wr_status && wdata[BIT_SOFT];
  assign soft_retrig = bus_ok && wr.wr_clear && st_q[BIT_SOFT] && !wdata[BIT_SOFT];
  assign soft_fire   = soft_req || soft_retrig;

  always_comb begin
    st_d = st_q;
    if (bus_ok && wr.wr_clear) st_d = st_d & ~wdata;
    if (soft_req)              st_d[BIT_SOFT] = 1'b1;
    // hardware sets win over a same-cycle clear
    if (wdog_hit)              st_d[BIT_WDOG] = 1'b1;
    if (ext_hit)               st_d[BIT_EXT]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= W'(1) << BIT_POR;
    else        st_q <= st_d;
  end

  assign status = st_q;

  AST_RETRIG_KEEPS_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
    soft_retrig |=> st_q[BIT_SOFT]); // R7
  AST_WDOG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_hit |=> st_q[BIT_WDOG]); // R3
  AST_EXT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ext_hit |=> st_q[BIT_EXT]); // R4
  AST_POR_BIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[BIT_POR] && !(bus_ok && wr.wr_clear && wdata[BIT_POR])) |=> st_q[BIT_POR]); // R6
endmodule

// File: rtl/rcc_pulse.sv
module rcc_pulse #(
  parameter int PULSE_LEN = 16,
  localparam int CNT_W = $clog2(PULSE_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active,
  output logic por_window
);
  logic [CNT_W-1:0] cnt_q;
  logic             por_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= CNT_W'(PULSE_LEN);
    else if (fire)           cnt_q <= CNT_W'(PULSE_LEN);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        por_q <= 1'b1;
    else if (!fire && cnt_q == CNT_W'(1)) por_q <= 1'b0;
  end

  assign active     = (cnt_q != '0);
  assign por_window = por_q;

  AST_FIRE_STARTS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> active); // R2
  AST_POR_INSIDE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    por_q |-> active); // R9
  AST_NO_LATE_POR: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(por_q)); // R9
endmodule

// File: rtl/rcc_remap.sv
module rcc_remap (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_ok,
  input  logic wr_remap,
  input  logic wbit,
  input  logic any_fire,
  output logic ram_sel
);
  logic sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  sel_q <= 1'b0;
    else if (any_fire)           sel_q <= 1'b0;
    else if (bus_ok && wr_remap) sel_q <= wbit;
  end

  assign ram_sel = sel_q;

  AST_RESET_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
    any_fire |=> !sel_q); // R8
  AST_BUSY_HOLDS_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ok && !any_fire) |=> $stable(sel_q)); // R10
endmodule

// File: rtl/reset_cause_ctl.sv
module reset_cause_ctl
  import rcc_pkg::*;
#(
  parameter int PULSE_LEN   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wdog_evt,
  input  logic              ext_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              sys_rst,
  output logic              wdt_rst,
  output logic              remap_ram
);
  logic               rst_n;
  logic               ext_low;
  logic               bus_ok;
  logic               soft_fire;
  logic               any_fire;
  logic               pulse_on;
  logic               por_win;
  logic [CAUSE_W-1:0] status;
  reg_wr_t            wr;

  // release of power-on reset is synchronized; assertion is immediate
  rcc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_por_sync (
    .clk(clk), .arst_n(por_n), .d(1'b1), .q(rst_n)
  );

  logic ext_sync_n;
  rcc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ext_sync (
    .clk(clk), .arst_n(rst_n), .d(ext_rst_n), .q(ext_sync_n)
  );
  assign ext_low = !ext_sync_n;

  assign bus_ok       = !pulse_on;
  assign wr.wr_status = wr_en && (addr == OFS_STATUS);
  assign wr.wr_clear  = wr_en && (addr == OFS_CLEAR);
  assign wr.wr_remap  = wr_en && (addr == OFS_REMAP);

  rcc_cause #(.W(CAUSE_W)) u_cause (
    .clk(clk), .rst_n(rst_n), .bus_ok(bus_ok), .wr(wr),
    .wdata(wdata[CAUSE_W-1:0]), .wdog_hit(wdog_evt), .ext_hit(ext_low),
    .status(status), .soft_fire(soft_fire)
  );

  assign any_fire = soft_fire || wdog_evt || ext_low;

  rcc_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(any_fire),
    .active(pulse_on), .por_window(por_win)
  );

  rcc_remap u_remap (
    .clk(clk), .rst_n(rst_n), .bus_ok(bus_ok), .wr_remap(wr.wr_remap),
    .wbit(wdata[0]), .any_fire(any_fire), .ram_sel(remap_ram)
  );

  always_comb begin
    rdata = '0;
    if (addr == OFS_STATUS)     rdata[CAUSE_W-1:0] = status;
    else if (addr == OFS_REMAP) rdata[0] = remap_ram;
  end

  assign sys_rst = pulse_on || !rst_n;
  assign wdt_rst = por_win  || !rst_n;

  AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFS_STATUS) |-> (rdata[DATA_W-1:CAUSE_W] == '0)); // R6
  AST_REMAP_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFS_REMAP) |-> (rdata[DATA_W-1:1] == '0)); // R8
  AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFS_CLEAR) |-> (rdata == '0)); // R6
  AST_WDT_NOT_FROM_WDOG: assert property (@(posedge clk) disable iff (!rst_n)
    (wdog_evt && !wdt_rst) |=> !wdt_rst); // R9
endmodule

// File: tb/tb_reset_cause_ctl.sv
module tb_reset_cause_ctl;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       wdog_evt = 1'b0;
  logic       ext_rst_n = 1'b1;
  logic       wr_en = 1'b0;
  logic [11:0] addr = 12'h000;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       sys_rst, wdt_rst, remap_ram;

  int n_chk = 0, n_bad = 0;
  logic [3:0] m_st;
  logic       m_remap;

  always #5 clk = ~clk;

  reset_cause_ctl dut (
    .clk(clk), .por_n(por_n), .wdog_evt(wdog_evt), .ext_rst_n(ext_rst_n),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .sys_rst(sys_rst), .wdt_rst(wdt_rst), .remap_ram(remap_ram)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] f_clear(input logic [3:0] st, input logic [7:0] d);
    return st & ~d[3:0];
  endfunction

  function automatic bit f_retrig(input logic [3:0] st, input logic [7:0] d);
    return st[2] && !d[2];
  endfunction

  task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 12'h000; wdata = 8'h00;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
    addr = 12'h000;
  endtask

  task automatic count_high(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      if (sys_rst) c++;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    while (sys_rst) @(negedge clk);
  endtask

  task automatic check_regs(input string req);
    logic [7:0] v;
    bus_rd(12'h230, v);
    check(v == {4'h0, m_st}, req, v, {4'h0, m_st});
    bus_rd(12'h220, v);
    check(v == {7'h0, m_remap}, req, v, {7'h0, m_remap});
  endtask

  task automatic do_por();
    int c, w;
    @(negedge clk);
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    c = 0; w = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sys_rst) c++;
      if (wdt_rst) w++;
    end
    check(c == 17, "R1 sys_rst length after power-on", c, 17);
    check(w == 17, "R1 wdt_rst length after power-on", w, 17);
    m_st = 4'h1; m_remap = 1'b0;
    check_regs("R1 state after power-on");
  endtask

  initial begin
    int c, w, h;
    logic [7:0] v, d;
    void'($urandom(32'd1234));
    fork
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    join_none

    // power-on from time zero
    repeat (3) @(negedge clk);
    check(sys_rst && wdt_rst, "R1 resets held while por_n low", {sys_rst, wdt_rst}, 3);
    do_por();

    // remap set, reserved bits
    bus_wr(12'h220, 8'hFF);
    m_remap = 1'b1;
    check(remap_ram == 1'b1, "R8 remap set", remap_ram, 1);
    bus_rd(12'h220, v);
    check(v == 8'h01, "R8 reserved remap bits", v, 1);

    // watchdog pulse: R2, R3, R9, remap back to flash
    @(negedge clk); wdog_evt = 1'b1;
    @(negedge clk); wdog_evt = 1'b0;
    check(wdt_rst == 1'b0, "R9 no wdt_rst on watchdog reset", wdt_rst, 0);
    count_high(40, c);
    check(c == 16, "R2 watchdog pulse length", c, 16);
    m_st[1] = 1'b1; m_remap = 1'b0;
    check_regs("R3 watchdog cause kept with power-on bit, R8 remap cleared");

    // software reset via status write, other bits ignored
    bus_wr(12'h230, 8'hFB);
    check(sys_rst == 1'b0, "R5 no trigger without bit 2", sys_rst, 0);
    check_regs("R5 status bits other than 2 not writable");
    bus_wr(12'h230, 8'h04);
    count_high(40, c);
    check(c == 16, "R5 software pulse length", c, 16);
    m_st[2] = 1'b1;
    check_regs("R5 software bit set");

    // R10: writes during pulse ignored
    bus_wr(12'h230, 8'h04);
    bus_wr(12'h220, 8'h01);
    bus_wr(12'h234, 8'h0F);
    wait_idle();
    check_regs("R10 writes ignored while sys_rst high");

    // R7: clear that spares bit 2 retriggers
    bus_wr(12'h234, 8'h01);
    count_high(40, c);
    check(c == 16, "R7 retrigger pulse length", c, 16);
    m_st = f_clear(m_st, 8'h01);
    check_regs("R7 bit 2 kept after retrigger");

    // R6: clear including bit 2, read of clear offset
    bus_wr(12'h234, 8'hF4);
    check(sys_rst == 1'b0, "R6 clearing bit 2 does not retrigger", sys_rst, 0);
    m_st = f_clear(m_st, 8'hF4);
    check_regs("R6 clear register");
    bus_rd(12'h234, v);
    check(v == 8'h00, "R6 clear register reads zero", v, 0);
    bus_rd(12'h3FC, v);
    check(v == 8'h00, "R12 unmapped offset reads zero", v, 0);

    // R2: restart during pulse
    @(negedge clk); wdog_evt = 1'b1;
    @(negedge clk); wdog_evt = 1'b0;
    repeat (5) @(negedge clk);
    wdog_evt = 1'b1;
    @(negedge clk); wdog_evt = 1'b0;
    count_high(40, c);
    check(c == 16, "R2 restart of count", c, 16);
    m_st[1] = 1'b1;

    // R4: external pin held 5 cycles
    h = 5;
    c = 0; w = 0;
    @(negedge clk); ext_rst_n = 1'b0;
    for (int i = 0; i < h + 40; i++) begin
      if (i == h) ext_rst_n = 1'b1;
      if (sys_rst) c++;
      if (wdt_rst) w++;
      @(negedge clk);
    end
    check(c == h + 15, "R4 external reset length", c, h + 15);
    check(w == 0, "R9 no wdt_rst on external reset", w, 0);
    m_st[3] = 1'b1;
    check_regs("R4 external cause bit");

    // R11: clear all and watchdog event in the same cycle
    bus_wr(12'h220, 8'h01);
    @(negedge clk);
    wr_en = 1'b1; addr = 12'h234; wdata = 8'h0F; wdog_evt = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = 12'h000; wdata = 8'h00; wdog_evt = 1'b0;
    count_high(40, c);
    check(c == 16, "R11 pulse on overlap", c, 16);
    m_st = 4'h2; m_remap = 1'b0;
    check_regs("R11 set wins over same-cycle clear");

    // constrained random mix
    for (int it = 0; it < 60; it++) begin
      int op;
      op = $urandom_range(0, 3);
      d = 8'($urandom);
      case (op)
        0: begin
          bus_wr(12'h234, d);
          if (f_retrig(m_st, d)) m_remap = 1'b0;
          m_st = f_clear(m_st, d);
        end
        1: begin
          bus_wr(12'h230, d);
          if (d[2]) begin m_st[2] = 1'b1; m_remap = 1'b0; end
        end
        2: begin
          bus_wr(12'h220, d);
          m_remap = d[0];
        end
        default: begin
          @(negedge clk); wdog_evt = 1'b1;
          @(negedge clk); wdog_evt = 1'b0;
          m_st[1] = 1'b1; m_remap = 1'b0;
        end
      endcase
      wait_idle();
      check_regs("R3 R5 R6 R7 R8 random sequence");
    end

    // power-on in the middle of operation
    bus_wr(12'h220, 8'h01);
    bus_wr(12'h230, 8'h04);
    wait_idle();
    do_por();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule